// File: doc/BRIEF.md
# Two-Master Shared Bus Arbiter

This block decides which of two masters may drive a shared address/data bus: a host processor and a serial-bus terminal controller. Each master asks for the bus with an active-low request. It receives an active-low grant and answers with an active-low acknowledge. The acknowledge tells the arbiter that the master is now moving data on the shared bus. The arbiter grants one master at a time, and the terminal controller wins a tie. The grant is dropped once the acknowledge arrives, and the bus stays owned until the acknowledge is released.

While a master owns the bus, the shared RAM chip select paces its transfers. Each time the chip select returns high after an access, the owner gets a one-cycle active-low transfer acknowledge, which marks that the access through the bridge has completed. Several transfers may follow one another within a single ownership.

A bus-in-use flag and a three-bit status code go to the bridge and datapath control logic. A granted master that withdraws its request without ever acknowledging loses its grant after a fixed timeout. All five active-low inputs arrive from other clock domains and pass through two-flop synchronisers.

States:
- `ST_IDLE`: nothing granted.
- `ST_GNT_H` / `ST_GNT_T`: grant driven to the host or the terminal controller.
- `ST_OWN_H` / `ST_OWN_T`: acknowledge seen and grant released.
- `ST_XAK_H` / `ST_XAK_T`: one-cycle transfer acknowledge.

Transitions:
- IDLE→GNT_T when the terminal controller requests.
- IDLE→GNT_H when only the host requests.
- GNT→OWN when the acknowledge is seen.
- GNT→IDLE when the timeout expires.
- OWN→XAK when the chip select rises.
- OWN→IDLE when the acknowledge is released.
- XAK→OWN while the acknowledge is held.
- XAK→IDLE when the acknowledge is released.

Top module: `arb_shared_bus`

## Requirements
- R1: While reset is asserted, and directly after it, both grants and both transfer acknowledges are high, `bus_busy` is 0 and `stat` is 3'b000.
- R2: A request from a single master in the idle state pulls that master's grant low. The grant appears three rising clock edges after the request input falls, and `bus_busy` rises with it.
- R3: When both requests are low in the same cycle while idle, only the terminal controller is granted.
- R4: Once the granted master's acknowledge goes low, its grant returns high and `bus_busy` stays 1.
- R5: While a master owns the bus, a low-to-high change of `ram_cs_n` gives that master exactly one cycle of low transfer acknowledge, three rising edges after the change. The other master's transfer acknowledge stays high.
- R6: If the acknowledge is still held after a transfer acknowledge, ownership continues, and later chip-select pulses each give another one-cycle transfer acknowledge.
- R7: When the owner releases its acknowledge, `bus_busy` falls three rising edges later. A request still pending from the other master is granted one edge after that.
- R8: No grant is issued while `bus_busy` is 1. A request from the other master during an ownership stays ungranted.
- R9: If a granted master raises its request without having acknowledged, its grant is withdrawn on the 18th rising edge after the request input rises. This is 16 counted cycles after synchronisation. A grant whose request stays low is held indefinitely.
- R10: The two grants are never low at the same time.
- R11: `stat[2]` is 1 when the terminal controller is the active master and 0 otherwise. `stat[1:0]` is the phase: 00 idle, 01 granted, 10 owned, 11 transfer acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_n | input | 1 | Host bus request, active low |
| host_ack_n | input | 1 | Host bus acknowledge, active low |
| term_req_n | input | 1 | Terminal controller bus request, active low |
| term_ack_n | input | 1 | Terminal controller bus acknowledge, active low |
| ram_cs_n | input | 1 | Shared RAM chip select, active low |
| host_grant_n | output | 1 | Grant to host, active low |
| term_grant_n | output | 1 | Grant to terminal controller, active low |
| host_xack_n | output | 1 | Transfer acknowledge to host, active low |
| term_xack_n | output | 1 | Transfer acknowledge to terminal controller, active low |
| bus_busy | output | 1 | Shared bus in use |
| stat | output | 3 | Side and phase status code |

## Verification
Every input passes two synchroniser flops before it reaches the state register, and the outputs are decoded from that register. A grant, a grant release, a transfer acknowledge or a drop of `bus_busy` is therefore due three rising edges after the input that causes it. A pending second grant is due one edge after that. The bench changes inputs on falling edges and samples on the third falling edge that follows, or on the fourth for the second grant. It also samples one edge later to confirm that each transfer acknowledge lasts a single cycle. The timeout is checked on the falling edges just before and just after the 18th rising edge, so a counter that is off by one cycle is caught.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GNT_H = 3'd1,
        ST_OWN_H = 3'd2,
        ST_XAK_H = 3'd3,
        ST_GNT_T = 3'd4,
        ST_OWN_T = 3'd5,
        ST_XAK_T = 3'd6
    } arb_state_e;

    localparam logic [1:0] PH_IDLE = 2'b00;
    localparam logic [1:0] PH_GNT  = 2'b01;
    localparam logic [1:0] PH_OWN  = 2'b10;
    localparam logic [1:0] PH_XAK  = 2'b11;

    localparam int SYNC_W = 5;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '1;
                    else        stg[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '1;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/arb_tmo.sv
module arb_tmo #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expire
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en)    cnt_q <= '0;
        else if (expire) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = en && (cnt_q == LAST);

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_req,
    input  logic       h_ack,
    input  logic       t_req,
    input  logic       t_ack,
    input  logic       cs_rise,
    input  logic       tmo_exp,
    output logic       tmo_en,
    output logic       host_grant_n,
    output logic       term_grant_n,
    output logic       host_xack_n,
    output logic       term_xack_n,
    output logic       bus_busy,
    output logic [2:0] stat
);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (t_req)      state_d = ST_GNT_T;
                else if (h_req) state_d = ST_GNT_H;
            end
            ST_GNT_H: begin
                if (h_ack)        state_d = ST_OWN_H;
                else if (tmo_exp) state_d = ST_IDLE;
            end
            ST_OWN_H: begin
                if (!h_ack)       state_d = ST_IDLE;
                else if (cs_rise) state_d = ST_XAK_H;
            end
            ST_XAK_H: begin
                if (h_ack) state_d = ST_OWN_H;
                else       state_d = ST_IDLE;
            end
            ST_GNT_T: begin
                if (t_ack)        state_d = ST_OWN_T;
                else if (tmo_exp) state_d = ST_IDLE;
            end
            ST_OWN_T: begin
                if (!t_ack)       state_d = ST_IDLE;
                else if (cs_rise) state_d = ST_XAK_T;
            end
            ST_XAK_T: begin
                if (t_ack) state_d = ST_OWN_T;
                else       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        host_grant_n = 1'b1;
        term_grant_n = 1'b1;
        host_xack_n  = 1'b1;
        term_xack_n  = 1'b1;
        bus_busy     = 1'b1;
        tmo_en       = 1'b0;
        stat         = {1'b0, PH_IDLE};
        unique case (state_q)
            ST_IDLE: begin
                bus_busy = 1'b0;
            end
            ST_GNT_H: begin
                host_grant_n = 1'b0;
                tmo_en       = !h_req && !h_ack;
                stat         = {1'b0, PH_GNT};
            end
            ST_OWN_H: begin
                stat = {1'b0, PH_OWN};
            end
            ST_XAK_H: begin
                host_xack_n = 1'b0;
                stat        = {1'b0, PH_XAK};
            end
            ST_GNT_T: begin
                term_grant_n = 1'b0;
                tmo_en       = !t_req && !t_ack;
                stat         = {1'b1, PH_GNT};
            end
            ST_OWN_T: begin
                stat = {1'b1, PH_OWN};
            end
            ST_XAK_T: begin
                term_xack_n = 1'b0;
                stat        = {1'b1, PH_XAK};
            end
            default: bus_busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/arb_shared_bus.sv
module arb_shared_bus
    import arb_pkg::*;
#(
    parameter int TMO_CYC     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req_n,
    input  logic       host_ack_n,
    input  logic       term_req_n,
    input  logic       term_ack_n,
    input  logic       ram_cs_n,
    output logic       host_grant_n,
    output logic       term_grant_n,
    output logic       host_xack_n,
    output logic       term_xack_n,
    output logic       bus_busy,
    output logic [2:0] stat
);

    logic [SYNC_W-1:0] raw_n, syn_n;
    logic cs_prev_q;
    logic cs_rise;
    logic tmo_en, tmo_exp;

    assign raw_n = {ram_cs_n, term_ack_n, term_req_n, host_ack_n, host_req_n};

    arb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_n),
        .q     (syn_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_prev_q <= 1'b1;
        else        cs_prev_q <= syn_n[4];
    end

    assign cs_rise = syn_n[4] && !cs_prev_q;

    arb_tmo #(.LIMIT(TMO_CYC)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tmo_en),
        .expire (tmo_exp)
    );

    arb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_req        (!syn_n[0]),
        .h_ack        (!syn_n[1]),
        .t_req        (!syn_n[2]),
        .t_ack        (!syn_n[3]),
        .cs_rise      (cs_rise),
        .tmo_exp      (tmo_exp),
        .tmo_en       (tmo_en),
        .host_grant_n (host_grant_n),
        .term_grant_n (term_grant_n),
        .host_xack_n  (host_xack_n),
        .term_xack_n  (term_xack_n),
        .bus_busy     (bus_busy),
        .stat         (stat)
    );

endmodule

// File: rtl/arb_shared_bus_chk.sv
module arb_shared_bus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_grant_n,
    input logic       term_grant_n,
    input logic       host_xack_n,
    input logic       term_xack_n,
    input logic       bus_busy,
    input logic [2:0] stat
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (host_grant_n && term_grant_n && host_xack_n
                                     && term_xack_n && !bus_busy && stat == 3'b000)
                else $error("outputs active during reset");
        end
    end

    // R10
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_grant_n && !term_grant_n));

    // R8
    host_gnt_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_grant_n) |-> !$past(bus_busy));

    // R8
    term_gnt_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_grant_n) |-> !$past(bus_busy));

    // R5
    host_xack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_xack_n |=> host_xack_n);

    // R5
    term_xack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_xack_n |=> term_xack_n);

    // R5
    xack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_xack_n && !term_xack_n));

    // R4
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_grant_n || !term_grant_n || !host_xack_n || !term_xack_n) |-> bus_busy);

    // R11
    stat_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy == (stat[1:0] != 2'b00));

    // R11
    stat_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_grant_n || !term_xack_n) |-> stat[2]);

endmodule

bind arb_shared_bus arb_shared_bus_chk u_chk (.*);

// File: tb/test_arb_shared_bus.sv
`timescale 1ns/1ps
module test_arb_shared_bus;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req_n = 1'b1, host_ack_n = 1'b1;
    logic term_req_n = 1'b1, term_ack_n = 1'b1;
    logic ram_cs_n = 1'b1;
    logic host_grant_n, term_grant_n, host_xack_n, term_xack_n, bus_busy;
    logic [2:0] stat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    arb_shared_bus i_arb_shared_bus (.*);

    // {host_req, term_req, exp_host_grant, exp_term_grant}, active high
    localparam logic [3:0] VEC [4] = '{4'b0000, 4'b1010, 4'b0101, 4'b1101};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_pulse();
        ram_cs_n = 1'b0;
        tick(3);
        ram_cs_n = 1'b1;
    endtask

    initial begin
        tick(2);
        // R1 during reset
        chk("R1 grants in reset", {6'd0, host_grant_n, term_grant_n}, 8'h3);
        chk("R1 xacks in reset", {6'd0, host_xack_n, term_xack_n}, 8'h3);
        chk("R1 busy/stat in reset", {4'd0, bus_busy, stat}, 8'h0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after reset", {4'd0, bus_busy, stat}, 8'h0);

        // table walk: R2 R3 R9
        for (int i = 0; i < 4; i++) begin
            host_req_n = !VEC[i][3];
            term_req_n = !VEC[i][2];
            tick(3);
            chk("R2/R3 host grant", {7'd0, !host_grant_n}, {7'd0, VEC[i][1]});
            chk("R2/R3 term grant", {7'd0, !term_grant_n}, {7'd0, VEC[i][0]});
            chk("R2 busy", {7'd0, bus_busy}, {7'd0, VEC[i][1] | VEC[i][0]});
            host_req_n = 1'b1;
            term_req_n = 1'b1;
            tick(20);
            chk("R9 back to idle", {4'd0, bus_busy, stat}, 8'h0);
        end

        // R9 exact withdrawal edge, host side
        host_req_n = 1'b0;
        tick(3);
        chk("R11 host granted stat", {5'd0, stat}, 8'h1);
        host_req_n = 1'b1;
        tick(17);
        chk("R9 grant before expiry", {7'd0, host_grant_n}, 8'h0);
        tick(1);
        chk("R9 grant withdrawn", {7'd0, host_grant_n}, 8'h1);
        chk("R9 busy after withdraw", {7'd0, bus_busy}, 8'h0);

        // R9 held request keeps grant
        term_req_n = 1'b0;
        tick(40);
        chk("R9 held term grant", {7'd0, term_grant_n}, 8'h0);
        chk("R11 term granted stat", {5'd0, stat}, 8'h5);
        term_req_n = 1'b1;
        tick(20);

        // host full transfer: R4 R5 R6 R7 R8
        host_req_n = 1'b0;
        tick(3);
        chk("R2 host grant", {7'd0, host_grant_n}, 8'h0);
        host_ack_n = 1'b0;
        tick(3);
        chk("R4 grant released", {7'd0, host_grant_n}, 8'h1);
        chk("R4 busy held", {7'd0, bus_busy}, 8'h1);
        chk("R11 owned stat", {5'd0, stat}, 8'h2);
        term_req_n = 1'b0;
        cs_pulse();
        tick(2);
        chk("R5 xack not yet", {7'd0, host_xack_n}, 8'h1);
        tick(1);
        chk("R5 host xack", {7'd0, host_xack_n}, 8'h0);
        chk("R5 term xack idle", {7'd0, term_xack_n}, 8'h1);
        chk("R11 xack stat", {5'd0, stat}, 8'h3);
        tick(1);
        chk("R5 xack single cycle", {7'd0, host_xack_n}, 8'h1);
        chk("R8 no term grant", {7'd0, term_grant_n}, 8'h1);
        cs_pulse();
        tick(3);
        chk("R6 second xack", {7'd0, host_xack_n}, 8'h0);
        tick(1);
        chk("R6 still owned", {5'd0, stat}, 8'h2);
        chk("R8 term still waiting", {7'd0, term_grant_n}, 8'h1);
        host_ack_n = 1'b1;
        host_req_n = 1'b1;
        tick(3);
        chk("R7 busy low", {7'd0, bus_busy}, 8'h0);
        chk("R7 no grant yet", {7'd0, term_grant_n}, 8'h1);
        tick(1);
        chk("R7 pending term granted", {7'd0, term_grant_n}, 8'h0);
        chk("R10 host grant off", {7'd0, host_grant_n}, 8'h1);

        // terminal transfer
        term_ack_n = 1'b0;
        tick(3);
        chk("R4 term owned", {5'd0, stat}, 8'h6);
        cs_pulse();
        tick(3);
        chk("R5 term xack", {7'd0, term_xack_n}, 8'h0);
        chk("R5 host xack idle", {7'd0, host_xack_n}, 8'h1);
        chk("R11 term xack stat", {5'd0, stat}, 8'h7);
        term_ack_n = 1'b1;
        term_req_n = 1'b1;
        tick(4);
        chk("R7 term released", {4'd0, bus_busy, stat}, 8'h0);

        // R1 reset in the middle of an ownership
        host_req_n = 1'b0;
        tick(3);
        host_ack_n = 1'b0;
        tick(3);
        rst_n = 1'b0;
        tick(1);
        chk("R1 mid reset", {4'd0, bus_busy, stat}, 8'h0);
        chk("R1 mid reset grants", {6'd0, host_grant_n, term_grant_n}, 8'h3);
        host_req_n = 1'b1;
        host_ack_n = 1'b1;
        rst_n = 1'b1;
        tick(4);
        chk("R1 idle after reset", {7'd0, bus_busy}, 8'h0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule